// File: doc/BRIEF.md
# RTC Alarm and Interrupt Controller

This block sits beside a real-time clock counter and turns its time fields and boundary pulses into interrupt events. It holds a set of packed-BCD alarm registers. On every seconds tick, while the clock is running, it compares them with the current time. When all fields match, it latches an alarm status flag.

It also latches one flag per boundary pulse: second, minute, hour and day. It keeps a power-up flag. A two-bit period select picks which boundary raises a periodic timer request. Every status flag is cleared by writing 1 to its bit. Software can therefore acknowledge everything pending by writing back the value it just read.

A single level interrupt line combines the alarm flag and the timer request, each gated by its own enable. The line stays high for as long as the alarm flag is set and enabled. Software tells an alarm interrupt from a periodic one by testing status bit 6.

The register port is a plain byte-wide bus. A write takes effect on the clock edge where the write strobe is high. Reads are combinational from the address. There is no data stream, so there is no valid/ready handshake, and the bus never back-pressures.

Top module: `rtc_alm_ctrl`

## Requirements
- R1: After reset, the six alarm registers and the interrupt control register read 0x00, the status register reads 0x80 (with clk_run low), and irq is low.
- R2: The alarm fields are full 8-bit read/write registers in this order: seconds 0x07, minutes 0x08, hours 0x09, day 0x0A, month 0x0B, year 0x0C.
- R3: The interrupt control register at 0x0F stores period select in bits 1:0, timer enable in bit 2 and alarm enable in bit 3. Bits 7:4 read as 0.
- R4: Status bit 6 is set when ev_sec is high, clk_run is high, and all six alarm fields equal the matching cur_time bytes. A mismatch in any one field, clk_run low, or no seconds tick leaves it clear.
- R5: Status bits 2 to 7 are cleared only by writing 1 to them at the status address 0x0E. A 0 bit has no effect. Writing back a read value clears every pending flag. A set and a clear of the same bit in the same cycle leave the bit set.
- R6: Status bits 2, 3, 4 and 5 are set by the ev_sec, ev_min, ev_hour and ev_day pulses respectively.
- R7: With timer enable set, a pulse on the boundary chosen by the period select sets a timer request; the other pulses do not. Period select encoding: 00 second, 01 minute, 10 hour, 11 day.
- R8: The timer request is cleared by any write to 0x0F and is held clear while timer enable is 0.
- R9: irq is high exactly when (status bit 6 and alarm enable) or (timer request and timer enable). It stays high on every cycle until status bit 6 is cleared.
- R10: Status bit 1 reads the current clk_run level. Status bit 0 reads 0.
- R11: Addresses other than 0x07 to 0x0C, 0x0E and 0x0F read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| cur_time | input | 48 | Current BCD time, byte i = field i (0 seconds ... 5 year) |
| clk_run | input | 1 | Clock core is counting |
| ev_sec | input | 1 | One-cycle seconds boundary pulse |
| ev_min | input | 1 | One-cycle minutes boundary pulse |
| ev_hour | input | 1 | One-cycle hours boundary pulse |
| ev_day | input | 1 | One-cycle days boundary pulse |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its defaults: six alarm fields, a 5-bit address and byte data. With those sizes it can sweep the whole address space for readback and every period-select against every boundary pulse (16 combinations). It also flips each alarm field in turn to prove that one differing byte blocks a match. The smaller scenarios cover the same-cycle set-versus-clear race, gating by clk_run, and write-back acknowledgement; their expected values come from the requirement rules alone.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 5;
  localparam int N_FIELDS = 6;
  localparam int N_EVENTS = 4;

  localparam logic [ADDR_W-1:0] ALM_BASE  = 5'h07;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 5'h0E;
  localparam logic [ADDR_W-1:0] ICTL_ADDR = 5'h0F;

  localparam int ST_RUN = 1;
  localparam int ST_EV0 = 2;
  localparam int ST_ALM = 6;
  localparam int ST_PWR = 7;

  typedef enum logic [1:0] {
    PER_SEC  = 2'd0,
    PER_MIN  = 2'd1,
    PER_HOUR = 2'd2,
    PER_DAY  = 2'd3
  } period_e;

  typedef struct packed {
    logic    alm_en;
    logic    tmr_en;
    period_e per;
  } ictl_t;
endpackage

// File: rtl/rtc_alm_regs.sv
module rtc_alm_regs
  import rtc_alm_pkg::*;
#(
  parameter int FIELDS = N_FIELDS,
  parameter int AW     = ADDR_W,
  parameter int BW     = BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [AW-1:0]        addr,
  input  logic [BW-1:0]        wdata,
  output logic [FIELDS*BW-1:0] alm_flat,
  output ictl_t                ictl,
  output logic                 ictl_wr
);
  localparam int ICTL_W = $bits(ictl_t);

  assign ictl_wr = wr && (addr == ICTL_ADDR);

  for (genvar i = 0; i < FIELDS; i++) begin : g_field
    localparam logic [AW-1:0] FADDR = AW'(ALM_BASE + i);
    logic [BW-1:0] fld_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    fld_q <= '0;
      else if (wr && addr == FADDR)  fld_q <= wdata;
    end
    assign alm_flat[i*BW +: BW] = fld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ictl <= '0;
    else if (ictl_wr) ictl <= ictl_t'(wdata[ICTL_W-1:0]);
  end

  a_r3_ictl_load: assert property (@(posedge clk) disable iff (!rst_n)
    ictl_wr |=> (ictl == $past(wdata[ICTL_W-1:0])));

  a_r3_ictl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ictl_wr |=> $stable(ictl));
endmodule

// File: rtl/rtc_alm_match.sv
module rtc_alm_match
  import rtc_alm_pkg::*;
#(
  parameter int FIELDS = N_FIELDS,
  parameter int BW     = BYTE_W
) (
  input  logic [FIELDS*BW-1:0] alm_flat,
  input  logic [FIELDS*BW-1:0] cur_time,
  output logic                 match
);
  logic [FIELDS-1:0] eq;

  for (genvar i = 0; i < FIELDS; i++) begin : g_cmp
    assign eq[i] = (alm_flat[i*BW +: BW] == cur_time[i*BW +: BW]);
  end

  assign match = &eq;
endmodule

// File: rtl/rtc_alm_status.sv
module rtc_alm_status
  import rtc_alm_pkg::*;
#(
  parameter int BW   = BYTE_W,
  parameter int NEVT = N_EVENTS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stat_wr,
  input  logic [BW-1:0]   wdata,
  input  logic [NEVT-1:0] ev,
  input  logic            clk_run,
  input  logic            match,
  input  ictl_t           ictl,
  input  logic            ictl_wr,
  output logic [BW-1:0]   status,
  output logic            irq
);
  logic [BW-1:0]   w1c;
  logic [NEVT-1:0] ev_flag;
  logic            alm_q, pwr_q, pend_q;
  logic            alm_set, sel_ev;

  assign w1c     = stat_wr ? wdata : '0;
  assign alm_set = ev[0] && clk_run && match;
  assign sel_ev  = ev[ictl.per];

  for (genvar k = 0; k < NEVT; k++) begin : g_evf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ev_flag[k] <= 1'b0;
      else        ev_flag[k] <= (ev_flag[k] & ~w1c[ST_EV0+k]) | ev[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_q  <= 1'b0;
      pwr_q  <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      alm_q <= (alm_q & ~w1c[ST_ALM]) | alm_set;
      pwr_q <= pwr_q & ~w1c[ST_PWR];
      if (!ictl.tmr_en)  pend_q <= 1'b0;
      else if (sel_ev)   pend_q <= 1'b1;
      else if (ictl_wr)  pend_q <= 1'b0;
    end
  end

  always_comb begin
    status                       = '0;
    status[ST_RUN]               = clk_run;
    status[ST_EV0 +: NEVT]       = ev_flag;
    status[ST_ALM]               = alm_q;
    status[ST_PWR]               = pwr_q;
  end

  assign irq = (alm_q & ictl.alm_en) | (pend_q & ictl.tmr_en);

  a_r4_alarm_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    alm_set |=> status[ST_ALM]);

  a_r5_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_ALM] && !(stat_wr && wdata[ST_ALM])) |=> status[ST_ALM]);

  a_r5_pwr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_PWR] && !(stat_wr && wdata[ST_PWR])) |=> status[ST_PWR]);

  a_r1_pwr_no_reassert: assert property (@(posedge clk) disable iff (!rst_n)
    !status[ST_PWR] |=> !status[ST_PWR]);

  a_r8_pend_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (ictl_wr && !sel_ev) |=> !pend_q);

  a_r9_irq_alarm_level: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_ALM] && ictl.alm_en) |-> irq);
endmodule

// File: rtl/rtc_alm_ctrl.sv
module rtc_alm_ctrl
  import rtc_alm_pkg::*;
#(
  parameter int FIELDS = N_FIELDS,
  parameter int AW     = ADDR_W,
  parameter int BW     = BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [AW-1:0]        reg_addr,
  input  logic [BW-1:0]        reg_wdata,
  output logic [BW-1:0]        reg_rdata,
  input  logic [FIELDS*BW-1:0] cur_time,
  input  logic                 clk_run,
  input  logic                 ev_sec,
  input  logic                 ev_min,
  input  logic                 ev_hour,
  input  logic                 ev_day,
  output logic                 irq
);
  localparam int ICTL_W = $bits(ictl_t);

  logic [FIELDS*BW-1:0] alm_flat;
  ictl_t                ictl;
  logic                 ictl_wr;
  logic                 match;
  logic [BW-1:0]        status;
  logic                 stat_wr;
  logic [N_EVENTS-1:0]  ev;

  assign ev      = {ev_day, ev_hour, ev_min, ev_sec};
  assign stat_wr = reg_wr && (reg_addr == STAT_ADDR);

  rtc_alm_regs #(.FIELDS(FIELDS), .AW(AW), .BW(BW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .alm_flat(alm_flat), .ictl(ictl), .ictl_wr(ictl_wr)
  );

  rtc_alm_match #(.FIELDS(FIELDS), .BW(BW)) u_match (
    .alm_flat(alm_flat), .cur_time(cur_time), .match(match)
  );

  rtc_alm_status #(.BW(BW), .NEVT(N_EVENTS)) u_status (
    .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .wdata(reg_wdata),
    .ev(ev), .clk_run(clk_run), .match(match), .ictl(ictl),
    .ictl_wr(ictl_wr), .status(status), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < FIELDS; i++) begin
      if (reg_addr == AW'(ALM_BASE + i)) reg_rdata = alm_flat[i*BW +: BW];
    end
    if (reg_addr == STAT_ADDR) reg_rdata = status;
    if (reg_addr == ICTL_ADDR) reg_rdata = BW'(ictl);
  end

  a_r11_no_unmapped_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr < ALM_BASE)) |=> ($stable(alm_flat) && $stable(ictl)));

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ICTL_ADDR) |-> (reg_rdata[BW-1:ICTL_W] == '0));
endmodule

// File: tb/rtc_alm_ctrl_tb_top.sv
module rtc_alm_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [47:0] cur_time = '0;
  logic        clk_run = 1'b0;
  logic        ev_sec = 1'b0, ev_min = 1'b0, ev_hour = 1'b0, ev_day = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  rtc_alm_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cur_time(cur_time),
    .clk_run(clk_run), .ev_sec(ev_sec), .ev_min(ev_min), .ev_hour(ev_hour),
    .ev_day(ev_day), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic set_ev(input int k, input logic v);
    case (k)
      0: ev_sec = v;
      1: ev_min = v;
      2: ev_hour = v;
      default: ev_day = v;
    endcase
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input int k);
    @(negedge clk);
    set_ev(k, 1'b1);
    @(negedge clk);
    set_ev(k, 1'b0);
  endtask

  localparam logic [47:0] T0 = {8'h24, 8'h06, 8'h15, 8'h12, 8'h30, 8'h45};

  initial begin
    logic [7:0] v;
    logic [7:0] st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 6; i++) begin
      rd(5'(7 + i), v); check("R1 alarm reg reset", v, 8'h00);
    end
    rd(5'h0F, v); check("R1 ictl reset", v, 8'h00);
    rd(5'h0E, v); check("R1 status reset", v, 8'h80);
    check("R1 irq reset", {7'd0, irq}, 8'h00);

    // R5: writing 0 leaves power flag, writing 1 clears it
    wr(5'h0E, 8'h00);
    rd(5'h0E, v); check("R5 zero write keeps pwr", v, 8'h80);
    wr(5'h0E, 8'h80);
    rd(5'h0E, v); check("R5 w1c pwr", v, 8'h00);

    // R2 alarm field readback
    for (int i = 0; i < 6; i++) wr(5'(7 + i), 8'(8'h11 * (i + 1)));
    for (int i = 0; i < 6; i++) begin
      rd(5'(7 + i), v); check("R2 alarm field", v, 8'(8'h11 * (i + 1)));
    end

    // R3 ictl width
    wr(5'h0F, 8'hFF);
    rd(5'h0F, v); check("R3 ictl upper bits zero", v, 8'h0F);
    wr(5'h0F, 8'h00);

    // R11 unmapped addresses: write ones everywhere, read zero
    for (int a = 0; a < 32; a++) begin
      if (!((a >= 7 && a <= 12) || a == 14 || a == 15)) wr(5'(a), 8'hFF);
    end
    for (int a = 0; a < 32; a++) begin
      if (!((a >= 7 && a <= 12) || a == 14 || a == 15)) begin
        rd(5'(a), v); check("R11 unmapped reads zero", v, 8'h00);
      end
    end
    for (int i = 0; i < 6; i++) begin
      rd(5'(7 + i), v); check("R11 alarm untouched", v, 8'(8'h11 * (i + 1)));
    end
    rd(5'h0F, v); check("R11 ictl untouched", v, 8'h00);

    // R6 event flags, R5 write-back clear
    for (int k = 0; k < 4; k++) begin
      pulse(k);
      rd(5'h0E, v); check("R6 event flag", v, 8'(1 << (2 + k)));
      wr(5'h0E, v);
      rd(5'h0E, v); check("R5 write-back clears", v, 8'h00);
    end

    // R7 / R8 period sweep
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 4; k++) begin
        wr(5'h0F, 8'(4 | p));
        pulse(k);
        #1;
        check("R7 period select irq", {7'd0, irq}, (k == p) ? 8'h01 : 8'h00);
        if (k == p) begin
          wr(5'h0F, 8'(4 | p));
          #1; check("R8 ictl write clears request", {7'd0, irq}, 8'h00);
        end
        wr(5'h0E, 8'hFC);
      end
    end
    // R8 disable drops request, re-enable does not revive it
    wr(5'h0F, 8'h04);
    pulse(0);
    wr(5'h0F, 8'h00);
    #1; check("R8 disable clears", {7'd0, irq}, 8'h00);
    wr(5'h0F, 8'h05);
    #1; check("R8 no stale request", {7'd0, irq}, 8'h00);
    wr(5'h0E, 8'hFC);

    // R10 run bit
    clk_run = 1'b1;
    rd(5'h0E, v); check("R10 run bit", v, 8'h02);

    // R4 / R9 alarm match
    for (int i = 0; i < 6; i++) wr(5'(7 + i), T0[i*8 +: 8]);
    wr(5'h0F, 8'h08);
    cur_time = T0;
    pulse(0);
    rd(5'h0E, v); check("R4 match sets alarm", v & 8'h40, 8'h40);
    check("R9 irq on alarm", {7'd0, irq}, 8'h01);
    repeat (5) @(negedge clk);
    check("R9 irq level held", {7'd0, irq}, 8'h01);
    wr(5'h0E, 8'h40);
    #1; check("R9 irq drops after ack", {7'd0, irq}, 8'h00);
    wr(5'h0E, 8'hFC);

    // R4 single field mismatch sweep
    for (int f = 0; f < 6; f++) begin
      cur_time = T0 ^ (48'h01 << (f * 8));
      pulse(0);
      rd(5'h0E, v); check("R4 field mismatch", v & 8'h40, 8'h00);
      wr(5'h0E, 8'hFC);
    end
    cur_time = T0;

    // R4 clock stopped
    clk_run = 1'b0;
    pulse(0);
    rd(5'h0E, v); check("R4 stopped no alarm", v & 8'h40, 8'h00);
    clk_run = 1'b1;
    // R4 non-seconds tick
    pulse(1);
    rd(5'h0E, v); check("R4 minute tick no alarm", v & 8'h40, 8'h00);
    wr(5'h0E, 8'hFC);

    // R9 alarm disabled: flag set, irq low
    wr(5'h0F, 8'h00);
    pulse(0);
    rd(5'h0E, st); check("R9 flag without enable", st & 8'h40, 8'h40);
    check("R9 irq gated", {7'd0, irq}, 8'h00);

    // R5 set wins over clear in the same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'h0E; reg_wdata = 8'h40; ev_sec = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; ev_sec = 1'b0;
    rd(5'h0E, v); check("R5 set beats clear", v & 8'h40, 8'h40);
    wr(5'h0E, v);
    rd(5'h0E, v); check("R5 final write-back", v, 8'h02);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule